// File: doc/BRIEF.md
# Microcoded Sequencer for a Shared-Bus Processor Datapath

This block is the control unit of a small processor whose datapath hangs off one shared bus. The datapath holds a register file, with the program counter at index 32 and the link register at index 31. It also holds an instruction register, two operand latches A and B, an ALU, a memory address register and an immediate extender. Every cycle the controller reads one word from a control store, which is indexed by a microprogram counter. That word drives the datapath's load enables, bus-driver enables, write strobes and field selects. The word also carries a compact next-state code instead of a full successor address.

The sequencer has seven next-state codes: advance; spin while memory is busy; return to instruction fetch; dispatch on the 6-bit opcode; two conditional returns that depend on the datapath's zero flag; and a terminal hold. The microroutines cover fetch, register and immediate ALU operations, load, store, branch-if-zero and branch-if-nonzero, four jump forms, and an ALU operation whose operands and result all live in memory. The memory is reached through a port with a busy handshake. An opcode the dispatch table does not recognise parks the sequencer in a halt word that raises an illegal flag until reset.

Top module: `ucode_ctrl`

## Requirements
- R1: While `rst_n` is low, `upc` is 0, `illegal` is 0, and the fetch word is presented: `ld_ma`=1, `en_reg`=1, `reg_sel`=4, `reg_wr`=0, `mem_wr`=0. The `reg_sel` codes are: 0 the rs field (IR[25:21]), 1 the rt field (IR[20:16]), 2 the rd field (IR[15:11]), 3 register 31, 4 register 32 (PC).
- R2: Fetch takes four words. It loads MA from PC, loads IR from memory, loads A from PC, and then writes A+4 to PC and dispatches. The `alu_op` codes are: 0 A+B, 1 A+4, 2 func(A,B), 3 immediate-op(A,B), 4 jump target {A[31:28],B[25:0],00}, 5 pass A, 6 pass B.
- R3: A word that reads or writes memory (`en_mem` or `mem_wr`) is held for as long as `mem_busy` is high. It advances in the first cycle in which `mem_busy` is low.
- R4: Dispatch uses opcode 0x00 for register ALU, 0x09 for immediate ALU, 0x23 for load, 0x2B for store, 0x04 for branch-if-zero, 0x05 for branch-if-nonzero, 0x02 for jump, 0x06 for jump-register, 0x03 for jump-and-link, 0x07 for jump-and-link-register, and 0x1C for the memory-to-memory ALU operation.
- R5: Register ALU writes func(Reg[rs],Reg[rt]) to Reg[rd]. Immediate ALU writes op(Reg[rs],ext) to Reg[rt]. The `ext_sel` codes are: 0 the sign-extended IR[15:0], 1 the sign-extended IR[15:0] shifted left by 2, 2 IR[25:0] zero-extended.
- R6: Load computes MA = Reg[rs] + the sign-extended immediate and then writes the memory data to Reg[rt]. Store uses the same address and drives Reg[rt] onto the bus with `mem_wr`.
- R7: Branch-if-zero tests Reg[rs] through the zero flag. If the flag is set, PC becomes PC + (sign-extended immediate shifted left by 2); otherwise the sequencer returns to fetch at once. Branch-if-nonzero uses the opposite sense.
- R8: Jump and jump-and-link load PC with the jump target. Jump-register and jump-and-link-register load PC from Reg[rs]. Both link forms write the incremented PC to register 31. Jump-and-link-register reads Reg[rs] before it writes the link, so rs=31 jumps to the old link value.
- R9: The memory-to-memory operation writes func(M[Reg[rs]], M[Reg[rt]]) to M[Reg[rd]]. Each of its three memory accesses has its own spin wait.
- R10: In every word, at most one of `en_reg`, `en_imm`, `en_alu` and `en_mem` is high.
- R11: An opcode outside the R4 list leads to a halt word. There `illegal` is high, `upc` is frozen, and no load or write strobe is asserted until reset.
- R12: Counted from the first fetch word with no memory waits, an instruction takes this many cycles: 7 for register ALU, immediate ALU and jump; 9 for load and store; 8 for a taken branch, jump-and-link and jump-and-link-register; 5 for an untaken branch; 6 for jump-register; 11 for memory-to-memory. Each busy cycle adds one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| zero | input | 1 | High when the bus value is zero |
| mem_busy | input | 1 | Memory has not finished the current access |
| ld_ir | output | 1 | Load instruction register from bus |
| ld_a | output | 1 | Load operand latch A from bus |
| ld_b | output | 1 | Load operand latch B from bus |
| ld_ma | output | 1 | Load memory address register from bus |
| en_imm | output | 1 | Immediate extender drives bus |
| en_alu | output | 1 | ALU drives bus |
| en_reg | output | 1 | Register file drives bus |
| en_mem | output | 1 | Memory read data drives bus |
| reg_wr | output | 1 | Write bus value to selected register |
| mem_wr | output | 1 | Write bus value to memory at MA |
| reg_sel | output | 3 | Register index select (R1 codes) |
| ext_sel | output | 2 | Immediate form select (R5 codes) |
| alu_op | output | 3 | ALU function select (R2 codes) |
| upc | output | 6 | Microprogram counter |
| illegal | output | 1 | Sequencer parked on an unrecognised opcode |

## Verification
The hardest states to reach are the ones where a spin word lands on a busy cycle in each memory-touching routine. The three memory-to-memory accesses and the instruction fetch are the tightest of these. Only a datapath that answers the strobes can exercise them. The bench therefore runs a behavioural bus datapath and a memory that stretches every access by a random number of busy cycles, and it returns a poison value on the bus while busy, so an early capture corrupts the result. A jump-and-link-register through register 31 and a memory-to-memory operation whose three addresses coincide are set up by hand, because random fields rarely produce them.

// File: rtl/ucode_ctrl.sv
module ucode_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic       zero,
  input  logic       mem_busy,
  output logic       ld_ir,
  output logic       ld_a,
  output logic       ld_b,
  output logic       ld_ma,
  output logic       en_imm,
  output logic       en_alu,
  output logic       en_reg,
  output logic       en_mem,
  output logic       reg_wr,
  output logic       mem_wr,
  output logic [2:0] reg_sel,
  output logic [1:0] ext_sel,
  output logic [2:0] alu_op,
  output logic [5:0] upc,
  output logic       illegal
);

  localparam logic [2:0] J_NEXT = 3'd0, J_SPIN = 3'd1, J_FETCH = 3'd2, J_DISP = 3'd3,
                         J_FEQZ = 3'd4, J_FNEZ = 3'd5, J_HOLD = 3'd6;

  localparam logic [17:0] C_LIR = 18'h20000, C_LA  = 18'h10000, C_LB  = 18'h08000,
                          C_LMA = 18'h04000, C_IMM = 18'h02000, C_ALU = 18'h01000,
                          C_REG = 18'h00800, C_MEM = 18'h00400, C_RW  = 18'h00200,
                          C_MW  = 18'h00100;
  localparam logic [17:0] S_RS = 18'h00, S_RT = 18'h20, S_RD = 18'h40, S_LNK = 18'h60, S_PC = 18'h80;
  localparam logic [17:0] X_SE = 18'h00, X_BR = 18'h08, X_JT = 18'h10;
  localparam logic [17:0] O_ADD = 18'd0, O_INC4 = 18'd1, O_FUNC = 18'd2, O_OP = 18'd3,
                          O_JT = 18'd4, O_PA = 18'd5, O_PB = 18'd6;

  localparam logic [17:0] W_A_RS   = C_REG | S_RS | C_LA;
  localparam logic [17:0] W_A_PC   = C_REG | S_PC | C_LA;
  localparam logic [17:0] W_B_RT   = C_REG | S_RT | C_LB;
  localparam logic [17:0] W_B_SX   = C_IMM | X_SE | C_LB;
  localparam logic [17:0] W_B_BR   = C_IMM | X_BR | C_LB;
  localparam logic [17:0] W_B_JT   = C_IMM | X_JT | C_LB;
  localparam logic [17:0] W_MA_SUM = C_ALU | O_ADD | C_LMA;

  localparam logic [5:0] A_FETCH = 6'd0,  A_ALU  = 6'd4,  A_ALUI = 6'd7,  A_LW   = 6'd10,
                         A_SW    = 6'd15, A_BEQZ = 6'd20, A_BNEZ = 6'd24, A_J    = 6'd28,
                         A_JR    = 6'd31, A_JAL  = 6'd33, A_JALR = 6'd37, A_MM   = 6'd41,
                         A_HALT  = 6'd48;

  logic [17:0] cw;
  logic [2:0]  jt;
  logic [5:0]  disp, nxt, inc;

  always_comb begin
    cw = '0;
    jt = J_HOLD;
    case (upc)
      6'd0:         begin cw = C_REG | S_PC | C_LMA;           jt = J_NEXT;  end
      6'd1:         begin cw = C_MEM | C_LIR;                  jt = J_SPIN;  end
      6'd2:         begin cw = W_A_PC;                         jt = J_NEXT;  end
      6'd3:         begin cw = C_ALU | O_INC4 | C_RW | S_PC;   jt = J_DISP;  end
      6'd4:         begin cw = W_A_RS;                         jt = J_NEXT;  end
      6'd5:         begin cw = W_B_RT;                         jt = J_NEXT;  end
      6'd6:         begin cw = C_ALU | O_FUNC | C_RW | S_RD;   jt = J_FETCH; end
      6'd7:         begin cw = W_A_RS;                         jt = J_NEXT;  end
      6'd8:         begin cw = W_B_SX;                         jt = J_NEXT;  end
      6'd9:         begin cw = C_ALU | O_OP | C_RW | S_RT;     jt = J_FETCH; end
      6'd10, 6'd15: begin cw = W_A_RS;                         jt = J_NEXT;  end
      6'd11, 6'd16: begin cw = W_B_SX;                         jt = J_NEXT;  end
      6'd12, 6'd17: begin cw = W_MA_SUM;                       jt = J_NEXT;  end
      6'd13:        begin cw = C_MEM | C_RW | S_RT;            jt = J_SPIN;  end
      6'd18:        begin cw = C_REG | S_RT | C_MW;            jt = J_SPIN;  end
      6'd14, 6'd19: begin cw = '0;                             jt = J_FETCH; end
      6'd20:        begin cw = W_A_RS;                         jt = J_FNEZ;  end
      6'd24:        begin cw = W_A_RS;                         jt = J_FEQZ;  end
      6'd21, 6'd25: begin cw = W_A_PC;                         jt = J_NEXT;  end
      6'd22, 6'd26: begin cw = W_B_BR;                         jt = J_NEXT;  end
      6'd23, 6'd27: begin cw = C_ALU | O_ADD | C_RW | S_PC;    jt = J_FETCH; end
      6'd28:        begin cw = W_A_PC;                         jt = J_NEXT;  end
      6'd29:        begin cw = W_B_JT;                         jt = J_NEXT;  end
      6'd30:        begin cw = C_ALU | O_JT | C_RW | S_PC;     jt = J_FETCH; end
      6'd31:        begin cw = W_A_RS;                         jt = J_NEXT;  end
      6'd32:        begin cw = C_ALU | O_PA | C_RW | S_PC;     jt = J_FETCH; end
      6'd33:        begin cw = W_A_PC;                         jt = J_NEXT;  end
      6'd34:        begin cw = C_ALU | O_PA | C_RW | S_LNK;    jt = J_NEXT;  end
      6'd35:        begin cw = W_B_JT;                         jt = J_NEXT;  end
      6'd36:        begin cw = C_ALU | O_JT | C_RW | S_PC;     jt = J_FETCH; end
      6'd37:        begin cw = W_A_PC;                         jt = J_NEXT;  end
      6'd38:        begin cw = C_REG | S_RS | C_LB;            jt = J_NEXT;  end
      6'd39:        begin cw = C_ALU | O_PA | C_RW | S_LNK;    jt = J_NEXT;  end
      6'd40:        begin cw = C_ALU | O_PB | C_RW | S_PC;     jt = J_FETCH; end
      6'd41:        begin cw = C_REG | S_RS | C_LMA;           jt = J_NEXT;  end
      6'd42:        begin cw = C_MEM | C_LA;                   jt = J_SPIN;  end
      6'd43:        begin cw = C_REG | S_RT | C_LMA;           jt = J_NEXT;  end
      6'd44:        begin cw = C_MEM | C_LB;                   jt = J_SPIN;  end
      6'd45:        begin cw = C_REG | S_RD | C_LMA;           jt = J_NEXT;  end
      6'd46:        begin cw = C_ALU | O_FUNC | C_MW;          jt = J_SPIN;  end
      6'd47:        begin cw = '0;                             jt = J_FETCH; end
      default:      begin cw = '0;                             jt = J_HOLD;  end
    endcase
  end

  always_comb begin
    case (opcode)
      6'h00:   disp = A_ALU;
      6'h09:   disp = A_ALUI;
      6'h23:   disp = A_LW;
      6'h2B:   disp = A_SW;
      6'h04:   disp = A_BEQZ;
      6'h05:   disp = A_BNEZ;
      6'h02:   disp = A_J;
      6'h06:   disp = A_JR;
      6'h03:   disp = A_JAL;
      6'h07:   disp = A_JALR;
      6'h1C:   disp = A_MM;
      default: disp = A_HALT;
    endcase
  end

  assign inc = upc + 6'd1;

  always_comb begin
    case (jt)
      J_NEXT:  nxt = inc;
      J_SPIN:  nxt = mem_busy ? upc : inc;
      J_FETCH: nxt = A_FETCH;
      J_DISP:  nxt = disp;
      J_FEQZ:  nxt = zero ? A_FETCH : inc;
      J_FNEZ:  nxt = zero ? inc : A_FETCH;
      default: nxt = upc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) upc <= A_FETCH;
    else        upc <= nxt;

  assign {ld_ir, ld_a, ld_b, ld_ma, en_imm, en_alu, en_reg, en_mem,
          reg_wr, mem_wr, reg_sel, ext_sel, alu_op} = cw;
  assign illegal = (jt == J_HOLD);

  a_r3_spin_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_busy && (en_mem || mem_wr)) |=> (upc == $past(upc)));

  a_r2_fetch_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ir && !mem_busy) |=> (ld_a && en_reg && reg_sel == 3'd4));

  a_r10_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({en_imm, en_alu, en_reg, en_mem}) <= 1);

  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> (illegal && $stable(upc)));

  a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !(reg_wr || mem_wr || ld_ir || ld_a || ld_b || ld_ma));

endmodule

// File: tb/ucode_ctrl_bench.sv
`timescale 1ns/1ps
module ucode_ctrl_bench;
  logic clk = 0, rst_n = 0;
  logic [5:0] opcode = '0;
  logic zero = 0, mem_busy = 0;
  logic ld_ir, ld_a, ld_b, ld_ma, en_imm, en_alu, en_reg, en_mem, reg_wr, mem_wr, illegal;
  logic [2:0] reg_sel, alu_op;
  logic [1:0] ext_sel;
  logic [5:0] upc;

  ucode_ctrl u_ucode_ctrl (.clk(clk), .rst_n(rst_n), .opcode(opcode), .zero(zero), .mem_busy(mem_busy),
    .ld_ir(ld_ir), .ld_a(ld_a), .ld_b(ld_b), .ld_ma(ld_ma), .en_imm(en_imm), .en_alu(en_alu),
    .en_reg(en_reg), .en_mem(en_mem), .reg_wr(reg_wr), .mem_wr(mem_wr), .reg_sel(reg_sel),
    .ext_sel(ext_sel), .alu_op(alu_op), .upc(upc), .illegal(illegal));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int wmod = 1, left = 0, waits = 0;
  bit in_acc = 0;
  logic [31:0] rf [0:32];
  logic [31:0] erf [0:32];
  logic [31:0] mem [0:63];
  logic [31:0] emem [0:63];
  logic [31:0] ir = '0, ra = '0, rb = '0, ma = '0;

  task automatic check_eq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] rdreg(input logic [5:0] i);
    return (i == 6'd0) ? 32'h0 : rf[i];
  endfunction

  function automatic logic [5:0] sel_idx(input logic [2:0] s);
    case (s)
      3'd0: return {1'b0, ir[25:21]};
      3'd1: return {1'b0, ir[20:16]};
      3'd2: return {1'b0, ir[15:11]};
      3'd3: return 6'd31;
      3'd4: return 6'd32;
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic [31:0] bus_now();
    logic [31:0] v;
    v = '0;
    if (en_reg) v = rdreg(sel_idx(reg_sel));
    else if (en_imm)
      case (ext_sel)
        2'd0: v = sx(ir[15:0]);
        2'd1: v = sx(ir[15:0]) << 2;
        2'd2: v = {6'b0, ir[25:0]};
        default: v = '0;
      endcase
    else if (en_alu)
      case (alu_op)
        3'd0: v = ra + rb;
        3'd1: v = ra + 32'd4;
        3'd2: v = ra - rb;
        3'd3: v = ra ^ rb;
        3'd4: v = {ra[31:28], rb[25:0], 2'b00};
        3'd5: v = ra;
        3'd6: v = rb;
        default: v = '0;
      endcase
    else if (en_mem) v = mem_busy ? 32'hDEADBEEF : mem[ma[7:2]];
    return v;
  endfunction

  task automatic step();
    logic [31:0] b;
    logic lir, la, lb, lma, rw, mw;
    logic [5:0] wi;
    if (!(en_mem || mem_wr)) begin in_acc = 0; mem_busy = 0; end
    else begin
      if (!in_acc) begin in_acc = 1; left = $urandom % wmod; waits += left; end
      mem_busy = (left != 0);
      if (left != 0) left--;
    end
    b = bus_now();
    zero = (b == 32'h0);
    checks++;
    if ((32'(en_reg) + 32'(en_imm) + 32'(en_alu) + 32'(en_mem)) > 1) begin
      errors++;
      $display("FAIL R10 bus drivers: actual %b expected at most one", {en_reg, en_imm, en_alu, en_mem});
    end
    lir = ld_ir; la = ld_a; lb = ld_b; lma = ld_ma; rw = reg_wr; mw = mem_wr && !mem_busy;
    wi = sel_idx(reg_sel);
    @(posedge clk); #1;
    if (mw) mem[ma[7:2]] = b;
    if (lir) ir = b;
    if (la) ra = b;
    if (lb) rb = b;
    if (lma) ma = b;
    if (rw && wi != 6'd0) rf[wi] = b;
    opcode = ir[31:26];
    @(negedge clk);
  endtask

  task automatic do_ref(input logic [31:0] ins, output int base);
    logic [31:0] p4, a, b, jt, e, m1, m2, dd;
    logic [4:0] t, d;
    for (int i = 0; i < 33; i++) erf[i] = rf[i];
    for (int i = 0; i < 64; i++) emem[i] = mem[i];
    t = ins[20:16]; d = ins[15:11];
    p4 = rf[32] + 32'd4;
    erf[32] = p4;
    a = rdreg({1'b0, ins[25:21]});
    b = rdreg({1'b0, t});
    jt = {p4[31:28], ins[25:0], 2'b00};
    e = a + sx(ins[15:0]);
    base = 7;
    case (ins[31:26])
      6'h00: if (d != 0) erf[d] = a - b;
      6'h09: if (t != 0) erf[t] = a ^ sx(ins[15:0]);
      6'h23: begin base = 9; if (t != 0) erf[t] = mem[e[7:2]]; end
      6'h2B: begin base = 9; emem[e[7:2]] = b; end
      6'h04: if (a == 0) begin base = 8; erf[32] = p4 + (sx(ins[15:0]) << 2); end else base = 5;
      6'h05: if (a != 0) begin base = 8; erf[32] = p4 + (sx(ins[15:0]) << 2); end else base = 5;
      6'h02: erf[32] = jt;
      6'h06: begin base = 6; erf[32] = a; end
      6'h03: begin base = 8; erf[31] = p4; erf[32] = jt; end
      6'h07: begin base = 8; erf[31] = p4; erf[32] = a; end
      6'h1C: begin
        base = 11; m1 = mem[a[7:2]]; m2 = mem[b[7:2]]; dd = rdreg({1'b0, d});
        emem[dd[7:2]] = m1 - m2;
      end
      default: base = 0;
    endcase
  endtask

  task automatic compare_state(input string req);
    int bad;
    bad = -1;
    for (int i = 0; i < 33; i++) if (bad < 0 && rf[i] !== erf[i]) bad = i;
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s register %0d: actual %h expected %h", req, bad, rf[bad], erf[bad]);
    end
    bad = -1;
    for (int i = 0; i < 64; i++) if (bad < 0 && mem[i] !== emem[i]) bad = i;
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s memory word %0d: actual %h expected %h", req, bad, mem[bad], emem[bad]);
    end
  endtask

  task automatic run_instr(input logic [31:0] ins, input string req);
    int base, cyc;
    logic [31:0] pc;
    pc = rf[32];
    mem[pc[7:2]] = ins;
    do_ref(ins, base);
    check_eq("R2", "start at fetch word", {26'h0, upc}, 32'h0);
    waits = 0; cyc = 0;
    do begin step(); cyc++; end while (upc != 6'd0 && cyc < 200);
    check_eq("R12", "instruction cycles", cyc, base + waits);
    compare_state(req);
  endtask

  task automatic rand_state();
    rf[0] = '0;
    for (int i = 1; i < 33; i++) rf[i] = $urandom;
    rf[32][1:0] = 2'b00;
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
  endtask

  task automatic check_reset();
    check_eq("R1", "upc in reset", {26'h0, upc}, 32'h0);
    check_eq("R1", "illegal in reset", {31'h0, illegal}, 32'h0);
    check_eq("R1", "fetch word in reset", {27'h0, ld_ma, en_reg, reg_sel}, {27'h0, 1'b1, 1'b1, 3'd4});
    check_eq("R1", "no writes in reset", {30'h0, reg_wr, mem_wr}, 32'h0);
  endtask

  logic [5:0] ops [11] = '{6'h00, 6'h09, 6'h23, 6'h2B, 6'h04, 6'h05, 6'h02, 6'h06, 6'h03, 6'h07, 6'h1C};

  initial begin
    logic [31:0] ins, pc;
    logic [5:0] u0;
    int cyc;
    void'($urandom(32'd4021));
    rand_state();
    @(negedge clk);
    step(); step();
    #1 check_reset();
    rst_n = 1;

    wmod = 1;
    rand_state(); run_instr({6'h00, 5'd3, 5'd4, 5'd5, 11'h0}, "R2");
    rand_state(); run_instr({6'h00, 5'd3, 5'd4, 5'd0, 11'h0}, "R5");
    rand_state(); run_instr({6'h09, 5'd6, 5'd7, 16'h8001}, "R5");
    rand_state(); rf[2] = 32'h0000_00C0; run_instr({6'h23, 5'd2, 5'd9, 16'hFFF0}, "R6");
    rand_state(); run_instr({6'h2B, 5'd4, 5'd4, 16'h0008}, "R6");
    rand_state(); rf[6] = 0; run_instr({6'h04, 5'd6, 5'd0, 16'hFFFE}, "R7");
    rand_state(); rf[6] = 1; run_instr({6'h04, 5'd6, 5'd0, 16'h0010}, "R7");
    rand_state(); rf[6] = 5; run_instr({6'h05, 5'd6, 5'd0, 16'h0020}, "R7");
    rand_state(); rf[6] = 0; run_instr({6'h05, 5'd6, 5'd0, 16'h0020}, "R7");
    rand_state(); run_instr({6'h02, 26'h2AB_CDEF}, "R8");
    rand_state(); run_instr({6'h06, 5'd0, 21'h0}, "R8");
    rand_state(); run_instr({6'h03, 26'h155_1234}, "R8");
    rand_state(); run_instr({6'h07, 5'd31, 21'h0}, "R8");
    rand_state(); rf[8] = 32'h0000_00A4; run_instr({6'h1C, 5'd8, 5'd8, 5'd8, 11'h0}, "R9");
    wmod = 8;
    rand_state(); rf[1] = 32'h90; rf[2] = 32'hA0; rf[3] = 32'hB0;
    run_instr({6'h1C, 5'd1, 5'd2, 5'd3, 11'h0}, "R3");
    rand_state(); run_instr({6'h23, 5'd10, 5'd11, 16'h0004}, "R3");
    rand_state(); run_instr({6'h2B, 5'd10, 5'd11, 16'h0004}, "R3");

    rand_state();
    pc = rf[32];
    ins = {6'h3F, 26'h0};
    mem[pc[7:2]] = ins;
    for (int i = 0; i < 33; i++) erf[i] = rf[i];
    for (int i = 0; i < 64; i++) emem[i] = mem[i];
    erf[32] = pc + 32'd4;
    cyc = 0;
    do begin step(); cyc++; end while (!illegal && cyc < 60);
    check_eq("R11", "illegal raised", {31'h0, illegal}, 32'h1);
    u0 = upc;
    repeat (12) step();
    check_eq("R11", "upc frozen", {26'h0, upc}, {26'h0, u0});
    check_eq("R11", "illegal held", {31'h0, illegal}, 32'h1);
    compare_state("R11");
    rst_n = 0;
    #1 check_reset();
    step();
    rst_n = 1;
    check_eq("R1", "illegal cleared", {31'h0, illegal}, 32'h0);

    wmod = 4;
    for (int n = 0; n < 400; n++) begin
      logic [5:0] op;
      rand_state();
      op = ops[$urandom % 11];
      ins = {op, 26'($urandom)};
      if ((op == 6'h04 || op == 6'h05) && ($urandom % 2 == 1)) rf[ins[25:21]] = 0;
      rf[0] = 0;
      run_instr(ins, "R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL R12 watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule